// File: doc/BRIEF.md
# Bulk Bitwise AND/OR Command Sequencer

This block sits on the memory-controller side. It turns one bulk logic request into the row command stream that computes a row-wide AND or OR inside the memory array. The computation relies on majority sensing: three rows are opened together on the same bit lines, and the sense amplifiers settle to the majority of the three cells. If the third row holds all zeros, the result is the AND of the other two rows. If it holds all ones, the result is their OR. A request names two source rows, a destination row, the operation and a timing mode. The sequencer makes four row-to-row copies. Each copy opens a source row, opens a destination row without closing the first, and then closes the bank.

The copies run in a fixed order. The first source goes to scratch row 1 and the second source goes to scratch row 2. The constant row that selects the operation goes to scratch row 3. Last comes a copy whose opening activation is the simultaneous activation of all three scratch rows, with the request's destination as target. The source rows are therefore only ever read. In the slow mode every activation waits the full row-active time. In the fast mode the destination activation overlaps the source activation, which shortens every copy. All gaps are parameters counted in clock cycles. Requests arrive over a valid/ready handshake, and a one-cycle done pulse marks the end of each operation.

Top module: `bitop_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_op` is 00 with `cmd_row` 0, and `done` and `err` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle through the `done` cycle. A request held valid in the meantime is accepted on the first edge at which `req_ready` is 1 again.
- R3: The five top row addresses are reserved. With M = 2^ROW_W−1, they are scratch rows S1=M−4, S2=M−3 and S3=M−2, the zero row Z=M−1 and the ones row O=M. An accepted operation issues four copies in this order: A→S1, B→S2, constant→S3, triple→C. Each copy is an activate of its source, an activate of its destination, then a precharge. Command codes are 01 activate, 10 precharge, 11 triple activation of S1/S2/S3 (row field S1) and 00 none. A precharge carries the copy's destination row. When no command is issued, `cmd_row` is 0.
- R4: `req_op`=0 (AND) copies Z into S3. `req_op`=1 (OR) copies O into S3.
- R5: In slow mode (`req_fast`=0) the destination activate comes T_RAS cycles after the source activate. The precharge comes T_RAS cycles after the destination activate. The next copy begins T_RP cycles after the precharge.
- R6: In fast mode (`req_fast`=1) the destination activate comes one cycle after the source activate. The precharge comes T_RAS cycles after the source activate. The next copy begins T_RP cycles after the precharge.
- R7: `done` is high for exactly one cycle, T_RP cycles after the last precharge. The first ACT appears in the cycle after acceptance.
- R8: A request whose A, B or C is a reserved row produces an `err` pulse in the cycle after acceptance. No command is issued for it, and `req_ready` stays 1.
- R9: A destination activate only ever targets S1, S2, S3 or C, so source rows are never written.
- R10: Rows, operation and mode are sampled at acceptance. Input changes during an operation do not alter its command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_row_a | input | ROW_W | First source row |
| req_row_b | input | ROW_W | Second source row |
| req_row_c | input | ROW_W | Destination row |
| req_op | input | 1 | 0 = AND, 1 = OR |
| req_fast | input | 1 | 1 = overlapped (fast) timing |
| cmd_op | output | 2 | Command code this cycle |
| cmd_row | output | ROW_W | Row for the command |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The hardest situation to reach is a second request that arrives while an operation is running and also changes every field, mode included. It must be held off, must leave the running stream untouched, and must then start on exactly the edge after `done`. The stimulus raises a new request in the third cycle of a slow AND operation and keeps it valid. The bench then compares every cycle of both operations against streams it builds from the timing rules. Reserved-row requests and a destination equal to a source are covered by directed cases.

// File: rtl/bitop_seq.sv
module bitop_seq #(
  parameter int ROW_W = 10,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row_a,
  input  logic [ROW_W-1:0] req_row_b,
  input  logic [ROW_W-1:0] req_row_c,
  input  logic             req_op,
  input  logic             req_fast,
  output logic [1:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic             done,
  output logic             err
);
  localparam int CW = $clog2(2*T_RAS + T_RP + 2) + 1;
  localparam logic [ROW_W-1:0] ROW_O  = {ROW_W{1'b1}};
  localparam logic [ROW_W-1:0] ROW_Z  = ROW_O - ROW_W'(1);
  localparam logic [ROW_W-1:0] ROW_S3 = ROW_O - ROW_W'(2);
  localparam logic [ROW_W-1:0] ROW_S2 = ROW_O - ROW_W'(3);
  localparam logic [ROW_W-1:0] ROW_S1 = ROW_O - ROW_W'(4);
  localparam logic [1:0] C_NOP = 2'b00, C_ACT = 2'b01, C_PRE = 2'b10, C_TRI = 2'b11;

  logic             busy, op_q, fast_q;
  logic [ROW_W-1:0] a_q, b_q, c_q, src, dst;
  logic [1:0]       copy_q, phase_q;
  logic [CW-1:0]    wait_q, gap;

  wire bad    = (req_row_a >= ROW_S1) || (req_row_b >= ROW_S1) || (req_row_c >= ROW_S1);
  wire accept = req_valid && !busy;
  wire fire   = busy && (wait_q == '0);
  wire issue  = fire && (phase_q != 2'd3);

  assign req_ready = !busy;
  assign done      = fire && (phase_q == 2'd3);

  always_comb begin
    case (copy_q)
      2'd0:    begin src = a_q;                  dst = ROW_S1; end
      2'd1:    begin src = b_q;                  dst = ROW_S2; end
      2'd2:    begin src = op_q ? ROW_O : ROW_Z; dst = ROW_S3; end
      default: begin src = ROW_S1;               dst = c_q;    end
    endcase
  end

  always_comb begin
    case (phase_q)
      2'd0:    gap = fast_q ? CW'(1) : CW'(T_RAS);
      2'd1:    gap = fast_q ? CW'(T_RAS - 1) : CW'(T_RAS);
      default: gap = CW'(T_RP);
    endcase
  end

  always_comb begin
    cmd_op  = C_NOP;
    cmd_row = '0;
    if (issue) begin
      case (phase_q)
        2'd0:    begin cmd_op = (copy_q == 2'd3) ? C_TRI : C_ACT; cmd_row = src; end
        2'd1:    begin cmd_op = C_ACT; cmd_row = dst; end
        default: begin cmd_op = C_PRE; cmd_row = dst; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      err     <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      op_q    <= 1'b0;
      fast_q  <= 1'b0;
      copy_q  <= '0;
      phase_q <= '0;
      wait_q  <= '0;
    end else begin
      err <= accept && bad;
      if (accept) begin
        busy    <= !bad;
        a_q     <= req_row_a;
        b_q     <= req_row_b;
        c_q     <= req_row_c;
        op_q    <= req_op;
        fast_q  <= req_fast;
        copy_q  <= '0;
        phase_q <= '0;
        wait_q  <= '0;
      end else if (fire) begin
        if (done) begin
          busy <= 1'b0;
        end else begin
          wait_q <= gap - CW'(1);
          if (phase_q == 2'd2) begin
            if (copy_q == 2'd3) phase_q <= 2'd3;
            else begin
              phase_q <= 2'd0;
              copy_q  <= copy_q + 2'd1;
            end
          end else begin
            phase_q <= phase_q + 2'd1;
          end
        end
      end else if (busy) begin
        wait_q <= wait_q - CW'(1);
      end
    end
  end

  logic [CW-1:0] pre_age, act_age;
  logic          pre_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_age  <= '0;
      act_age  <= '0;
      pre_seen <= 1'b0;
    end else begin
      if (cmd_op == C_PRE) begin
        pre_age  <= CW'(1);
        pre_seen <= 1'b1;
      end else if (pre_age != {CW{1'b1}}) pre_age <= pre_age + CW'(1);
      if (cmd_op == C_ACT || cmd_op == C_TRI) act_age <= CW'(1);
      else if (act_age != {CW{1'b1}}) act_age <= act_age + CW'(1);
    end
  end

  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == C_ACT || cmd_op == C_TRI) && pre_seen) |-> pre_age >= CW'(T_RP)); // R5
  AST_RAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == C_PRE) |-> act_age >= (fast_q ? CW'(T_RAS - 1) : CW'(T_RAS))); // R5
  AST_FAST_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == C_ACT && fast_q && phase_q == 2'd1) |-> act_age == CW'(1)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cmd_op == C_NOP && req_ready)); // R8
  AST_DST_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == C_ACT && phase_q == 2'd1) |-> (cmd_row >= ROW_S1 && cmd_row <= ROW_S3) || cmd_row == c_q); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> !req_ready); // R2
endmodule

// File: tb/bitop_seq_tb.sv
module bitop_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10, RAS = 7, RP = 3;
  localparam logic [W-1:0] S1 = 10'd1019, S2 = 10'd1020, S3 = 10'd1021, ZR = 10'd1022, OR1 = 10'd1023;

  logic clk = 0, rst_n = 0, req_valid = 0, req_op = 0, req_fast = 0;
  logic [W-1:0] req_row_a = 0, req_row_b = 0, req_row_c = 0;
  logic req_ready, done, err;
  logic [1:0] cmd_op;
  logic [W-1:0] cmd_row;
  int tests = 0, fails = 0;
  logic stall_pending = 0;
  logic [31:0] stall_vec = 0;

  bitop_seq #(.ROW_W(W), .T_RAS(RAS), .T_RP(RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row_a(req_row_a), .req_row_b(req_row_b), .req_row_c(req_row_c),
    .req_op(req_op), .req_fast(req_fast), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: a[31:22] b[21:12] c[11:2] op[1] fast[0]
  localparam logic [31:0] VEC [6] = '{
    {10'd5,    10'd9,    10'd12,  1'b0, 1'b0},
    {10'd5,    10'd9,    10'd12,  1'b1, 1'b0},
    {10'd100,  10'd200,  10'd300, 1'b0, 1'b1},
    {10'd1018, 10'd0,    10'd77,  1'b1, 1'b1},
    {10'd40,   10'd41,   10'd40,  1'b0, 1'b0},
    {10'd0,    10'd1018, 10'd41,  1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v);
    req_row_a = v[31:22]; req_row_b = v[21:12]; req_row_c = v[11:2];
    req_op = v[1]; req_fast = v[0]; req_valid = 1;
  endtask

  task automatic check_run(input logic [31:0] v, input string extra);
    logic fast = v[0];
    int per = fast ? RAS + RP : 2*RAS + RP;
    int last = 4*per + 1;
    for (int t = 1; t <= last; t++) begin
      int k = (t - 1) / per;
      int off = (t - 1) % per;
      logic [1:0] eop = 2'b00;
      logic [W-1:0] erow = '0, src, dst;
      logic edone = (t == last);
      case (k)
        0: begin src = v[31:22]; dst = S1; end
        1: begin src = v[21:12]; dst = S2; end
        2: begin src = v[1] ? OR1 : ZR; dst = S3; end
        default: begin src = S1; dst = v[11:2]; end
      endcase
      if (!edone) begin
        if (off == 0) begin eop = (k == 3) ? 2'b11 : 2'b01; erow = src; end
        else if (off == (fast ? 1 : RAS)) begin eop = 2'b01; erow = dst; end
        else if (off == (fast ? RAS : 2*RAS)) begin eop = 2'b10; erow = dst; end
      end
      @(negedge clk);
      check(edone ? {"R7 done", extra} : (fast ? {"R3/R4/R6/R9 stream", extra} : {"R3/R4/R5/R9 stream", extra}),
            {16'd0, cmd_op, cmd_row, done, req_ready, err},
            {16'd0, eop, erow, edone, 1'b0, 1'b0});
      if (t == 3 && stall_pending) drive(stall_vec);
    end
  endtask

  task automatic start(input logic [31:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 reset", {16'd0, cmd_op, cmd_row, done, req_ready, err}, {16'd0, 2'b00, 10'd0, 1'b0, 1'b1, 1'b0});

    for (int i = 0; i < 6; i++) begin
      start(VEC[i]);
      check_run(VEC[i], "");
    end

    // R2 / R10: request raised mid-run with every field changed
    stall_vec = {10'd3, 10'd4, 10'd6, 1'b1, 1'b1};
    stall_pending = 1;
    start(VEC[0]);
    check_run(VEC[0], " R10");
    stall_pending = 0;
    @(negedge clk);
    check("R2 held request sees ready", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    #1 req_valid = 0;
    check_run(stall_vec, " R2");

    // R8: reserved rows rejected
    start({S1, 10'd2, 10'd3, 1'b0, 1'b0});
    @(negedge clk);
    check("R8 err pulse", {16'd0, cmd_op, cmd_row, done, req_ready, err}, {16'd0, 2'b00, 10'd0, 1'b0, 1'b1, 1'b1});
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check("R8 quiet", {16'd0, cmd_op, cmd_row, done, req_ready, err}, {16'd0, 2'b00, 10'd0, 1'b0, 1'b1, 1'b0});
    end
    start({10'd2, 10'd3, OR1, 1'b1, 1'b1});
    @(negedge clk);
    check("R8 err on C", {16'd0, cmd_op, cmd_row, done, req_ready, err}, {16'd0, 2'b00, 10'd0, 1'b0, 1'b1, 1'b1});
    start({10'd2, ZR, 10'd9, 1'b0, 1'b1});
    @(negedge clk);
    check("R8 err on B", {16'd0, cmd_op, cmd_row, done, req_ready, err}, {16'd0, 2'b00, 10'd0, 1'b0, 1'b1, 1'b1});
    @(negedge clk);
    check("R8 quiet after B", {16'd0, cmd_op, cmd_row, done, req_ready, err}, {16'd0, 2'b00, 10'd0, 1'b0, 1'b1, 1'b0});

    // valid request after rejections still runs
    start(VEC[2]);
    check_run(VEC[2], " after reject");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule